// File: doc/BRIEF.md
# UART Interrupt Priority and Identification Unit

This unit gathers the interrupt sources of a serial port controller, qualifies each with a bit of a small enable register, and produces two results: one registered interrupt line, and an identification byte that a CPU reads to learn which source needs service. When several sources are pending, only the most urgent one is reported. Line status errors come first. Received data and character timeout share the next level. The transmitter-empty source follows, and modem status changes come last.

The transmitter-empty source has no level condition to clear, so the unit keeps it in a latch of its own. The latch is set when the holding register or FIFO becomes empty, and also when its enable bit is switched on while the holding side is already empty. It is cleared when the CPU writes the holding register, or when the CPU reads the identification byte while that byte names transmitter-empty. The line status and modem status sources are latched from event pulses. Each is cleared by a read of its own status register. While a read of the identification byte is in progress, the reported byte stays frozen. New events are still latched during that time.

Top module: `uart_irq_ident`

## Requirements
- R1: Bit 0 of the identification byte is 0 while an enabled source is pending and 1 when none is pending. With nothing pending and FIFO mode off, the byte reads 0x01.
- R2: Bits 3:1 carry the reported source, highest priority first: line status 011, received data 010, character timeout 110 (reported only when received data is not also present), transmitter empty 001, modem status 000.
- R3: Bits 7:6 read 11 when `fifo_mode` is 1 and 00 when it is 0. Bits 5:4 always read 0. Bit 3 reads 0 when `fifo_mode` is 0, so a timeout then reads as received data (0x04).
- R4: Enable bit 0 qualifies received data and timeout. Bit 1 qualifies transmitter empty, bit 2 qualifies line status and bit 3 qualifies modem status. A disabled source neither appears in the byte nor raises `irq`.
- R5: The transmitter-empty latch is set on a 0-to-1 transition of `thr_empty`. It is also set by an enable write that changes bit 1 from 0 to 1 while `thr_empty` is 1.
- R6: The transmitter-empty latch clears on `thr_wr`. It also clears when an identification read ends while the frozen byte reports transmitter empty (bits 3:0 = 0010).
- R7: While `iir_rd` is 1 the identification byte holds its value. Events arriving during the read are kept and appear once the read ends.
- R8: The line status latch is set by `ls_set` and cleared by `lsr_rd`. The modem status latch is set by `ms_set` and cleared by `msr_rd`. A set in the same cycle as a clear wins.
- R9: `irq` is a registered signal. It is 1 exactly when some enabled source is pending, and outside reads it equals the inverse of bit 0 of the byte.
- R10: After reset the enable register reads 0x00, the identification byte reads 0x01 and `irq` is 0.
- R11: An enable write stores bits 3:0 of `ier_wdata`. Bits 7:4 of `ier_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| fifo_mode | input | 1 | FIFO mode active |
| ls_set | input | 1 | Line status error event pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_avail | input | 1 | Received data available (level) |
| rx_timeout | input | 1 | Character timeout (level) |
| thr_empty | input | 1 | Holding register or FIFO empty (level) |
| thr_wr | input | 1 | Holding register write strobe |
| ms_set | input | 1 | Modem status change event pulse |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_rd | input | 1 | Identification read in progress (level) |
| iir_rdata | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle: the end of an identification read that clears the transmitter-empty latch, and the arrival of a new line status event. The bench makes them coincide by pulsing `ls_set` on the cycle where `iir_rd` falls while the frozen byte reports transmitter empty. The transmitter-empty source must be gone for good. The line status source must appear on the following update rather than be lost. A behavioural model in the bench tracks this and the randomized traffic cycle by cycle.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_rdata,
  input  logic       fifo_mode,
  input  logic       ls_set,
  input  logic       lsr_rd,
  input  logic       rx_avail,
  input  logic       rx_timeout,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       ms_set,
  input  logic       msr_rd,
  input  logic       iir_rd,
  output logic [7:0] iir_rdata,
  output logic       irq
);
  logic [3:0] ier;
  logic ls_p, ms_p, te_p, thr_d, rd_d;
  logic [7:0] iir_q;
  logic [2:0] code;
  logic none;

  wire rd_end = rd_d & ~iir_rd;
  wire te_clr = thr_wr | (rd_end & (iir_q[3:0] == 4'h2));
  wire te_set = (thr_empty & ~thr_d) | (ier_we & ier_wdata[1] & ~ier[1] & thr_empty);

  wire ls_v = ier[2] & ls_p & ~lsr_rd;
  wire rx_v = ier[0] & rx_avail;
  wire to_v = ier[0] & rx_timeout;
  wire te_v = ier[1] & te_p & ~te_clr;
  wire ms_v = ier[3] & ms_p & ~msr_rd;

  always_comb begin
    code = 3'b000;
    none = 1'b0;
    if (ls_v)      code = 3'b011;
    else if (rx_v) code = 3'b010;
    else if (to_v) code = {fifo_mode, 2'b10};
    else if (te_v) code = 3'b001;
    else if (ms_v) code = 3'b000;
    else           none = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier   <= 4'h0;
      ls_p  <= 1'b0;
      ms_p  <= 1'b0;
      te_p  <= 1'b0;
      thr_d <= 1'b0;
      rd_d  <= 1'b0;
      iir_q <= 8'h01;
      irq   <= 1'b0;
    end else begin
      if (ier_we) ier <= ier_wdata[3:0];
      ls_p  <= ls_set | (ls_p & ~lsr_rd);
      ms_p  <= ms_set | (ms_p & ~msr_rd);
      te_p  <= te_set | (te_p & ~te_clr);
      thr_d <= thr_empty;
      rd_d  <= iir_rd;
      if (!iir_rd) iir_q <= {{2{fifo_mode}}, 2'b00, code, none};
      irq   <= ~none;
    end
  end

  assign ier_rdata = {4'h0, ier};
  assign iir_rdata = iir_q;
endmodule

module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_we,
  input logic [7:0] ier_wdata,
  input logic [7:0] ier_rdata,
  input logic       fifo_mode,
  input logic       ls_set,
  input logic       lsr_rd,
  input logic       rx_avail,
  input logic       rx_timeout,
  input logic       thr_empty,
  input logic       thr_wr,
  input logic       ms_set,
  input logic       msr_rd,
  input logic       iir_rd,
  input logic [7:0] iir_rdata,
  input logic       irq
);
  p_none_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rdata[0] |-> (iir_rdata[3:1] == 3'b000));
  p_fixed_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rdata[5:4] == 2'b00) && (iir_rdata[7] == iir_rdata[6]));
  p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ier_rdata == 8'h00) && !iir_rd) |=> (iir_rdata[0] && !irq));
  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !iir_rd) |=> (iir_rdata[3:0] != 4'h2));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    iir_rd |=> $stable(iir_rdata));
  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(iir_rd) |-> (irq == !iir_rdata[0]));
  p_ier_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ier_rdata[7:4] == 4'h0);
endmodule

bind uart_irq_ident uart_irq_ident_chk i_chk (.*);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ier_we = 0, fifo_mode = 0, ls_set = 0, lsr_rd = 0, rx_avail = 0, rx_timeout = 0;
  logic thr_empty = 0, thr_wr = 0, ms_set = 0, msr_rd = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0;
  logic [7:0] ier_rdata, iir_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (.*);

  // behavioural reference model
  int m_ier, m_iir, m_irq;
  bit m_ls, m_ms, m_te, m_thr_prev, m_in_read;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ier = 0; m_iir = 1; m_irq = 0;
      m_ls = 0; m_ms = 0; m_te = 0; m_thr_prev = 0; m_in_read = 0;
    end else begin
      bit read_done, te_gone, te_new, ls_on, ms_on, te_on;
      int val;
      read_done = m_in_read && !iir_rd;
      te_gone = thr_wr || (read_done && (m_iir % 16) == 2);
      te_new = (thr_empty && !m_thr_prev) ||
               (ier_we && ier_wdata[1] && ((m_ier & 2) == 0) && thr_empty);
      ls_on = ((m_ier & 4) != 0) && m_ls && !lsr_rd;
      ms_on = ((m_ier & 8) != 0) && m_ms && !msr_rd;
      te_on = ((m_ier & 2) != 0) && m_te && !te_gone;
      if (ls_on) val = 6;
      else if ((m_ier & 1) && rx_avail) val = 4;
      else if ((m_ier & 1) && rx_timeout) val = fifo_mode ? 12 : 4;
      else if (te_on) val = 2;
      else if (ms_on) val = 0;
      else val = 1;
      if (fifo_mode) val = val + 192;
      if (!iir_rd) m_iir = val;
      m_irq = (val % 2 == 0);
      if (ier_we) m_ier = ier_wdata % 16;
      m_ls = ls_set || (m_ls && !lsr_rd);
      m_ms = ms_set || (m_ms && !msr_rd);
      m_te = te_new || (m_te && !te_gone);
      m_thr_prev = thr_empty;
      m_in_read = iir_rd;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running) begin
    chk("R2 R3 model iir", iir_rdata, m_iir);
    chk("R9 model irq", irq, m_irq);
    chk("R11 model ier", ier_rdata, m_ier);
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wdata = v; ier_we = 1; cyc(); ier_we = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(); s = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    running = 1;
    cyc();
    chk("R10 reset iir", iir_rdata, 8'h01);
    chk("R10 reset ier", ier_rdata, 8'h00);
    chk("R10 reset irq", irq, 0);
    chk("R1 idle value", iir_rdata, 8'h01);

    wr_ier(8'hFF);
    chk("R11 ier upper bits zero", ier_rdata, 8'h0F);
    thr_empty = 1; cyc(2);
    chk("R5 rising empty sets", iir_rdata, 8'h02);
    chk("R9 irq raised", irq, 1);
    pulse(iir_rd); cyc();
    chk("R6 iir read clears empty", iir_rdata, 8'h01);

    wr_ier(8'h0D); wr_ier(8'h0F); cyc();
    chk("R5 enable while empty sets", iir_rdata, 8'h02);
    pulse(thr_wr); cyc();
    chk("R6 holding write clears", iir_rdata, 8'h01);

    fifo_mode = 1;
    pulse(ms_set); cyc();
    chk("R2 modem level", iir_rdata, 8'hC0);
    thr_empty = 0; cyc(); thr_empty = 1; cyc(2);
    chk("R2 empty over modem", iir_rdata, 8'hC2);
    rx_timeout = 1; cyc();
    chk("R2 timeout over empty", iir_rdata, 8'hCC);
    rx_avail = 1; cyc();
    chk("R2 data over timeout", iir_rdata, 8'hC4);
    pulse(ls_set); cyc();
    chk("R2 line status highest", iir_rdata, 8'hC6);
    fifo_mode = 0; cyc();
    chk("R3 non-fifo upper bits", iir_rdata, 8'h06);
    pulse(lsr_rd); cyc();
    chk("R8 lsr read clears", iir_rdata, 8'h04);
    rx_avail = 0; cyc();
    chk("R3 timeout bit3 forced", iir_rdata, 8'h04);
    rx_timeout = 0; cyc();
    chk("R2 back to empty", iir_rdata, 8'h02);
    pulse(thr_wr); cyc();
    chk("R2 modem remains", iir_rdata, 8'h00);
    pulse(msr_rd); cyc();
    chk("R8 msr read clears", iir_rdata, 8'h01);

    wr_ier(8'h00);
    ls_set = 1; ms_set = 1; cyc(); ls_set = 0; ms_set = 0;
    rx_avail = 1; cyc(2);
    chk("R4 disabled hidden", iir_rdata, 8'h01);
    chk("R4 disabled no irq", irq, 0);
    wr_ier(8'h04); cyc();
    chk("R4 line status enabled", iir_rdata, 8'h06);
    pulse(lsr_rd); wr_ier(8'h0F); cyc();
    chk("R2 data reported", iir_rdata, 8'h04);

    iir_rd = 1; cyc();
    pulse(ls_set); cyc(3);
    chk("R7 frozen during read", iir_rdata, 8'h04);
    iir_rd = 0; cyc();
    chk("R7 recorded event shown", iir_rdata, 8'h06);

    pulse(lsr_rd); rx_avail = 0; pulse(msr_rd);
    thr_empty = 0; cyc(); thr_empty = 1; cyc(2);
    chk("R5 empty again", iir_rdata, 8'h02);
    iir_rd = 1; cyc(); iir_rd = 0; ls_set = 1; cyc(); ls_set = 0;
    chk("R6 cleared at read end", iir_rdata, 8'h01);
    cyc();
    chk("R8 coincident event kept", iir_rdata, 8'h06);
    pulse(lsr_rd); cyc();
    chk("R6 empty stays cleared", iir_rdata, 8'h01);

    for (int k = 0; k < 3000; k++) begin
      ier_we = ($urandom % 8) == 0; ier_wdata = $urandom;
      fifo_mode = ($urandom % 16) != 0 ? fifo_mode : ~fifo_mode;
      ls_set = ($urandom % 10) == 0; lsr_rd = ($urandom % 8) == 0;
      ms_set = ($urandom % 10) == 0; msr_rd = ($urandom % 8) == 0;
      rx_avail = ($urandom % 6) != 0 ? rx_avail : ~rx_avail;
      rx_timeout = ($urandom % 6) != 0 ? rx_timeout : ~rx_timeout;
      thr_empty = ($urandom % 5) != 0 ? thr_empty : ~thr_empty;
      thr_wr = ($urandom % 9) == 0;
      iir_rd = ($urandom % 4) != 0 ? iir_rd : ~iir_rd;
      cyc();
    end
    {ier_we, ls_set, lsr_rd, ms_set, msr_rd, thr_wr, iir_rd} = '0;
    cyc(2);
    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule